// File: doc/BRIEF.md
# Clock Power Mode Controller

This block keeps track of which of three power modes a small SoC is in: Run, Halt or Standby. From that mode it drives two clock enables, one for the CPU clock and one for the system clock (bus and memory/DMA). It does not gate clocks itself. The clock gating cells downstream use the enables.

Software enters a low-power mode through a side-effect read. A read of the halt location, or of the standby location, takes effect only while the sleep-enable input is high. A falling edge on either interrupt line brings the block back to Run. So does either reset. A write to the clock-setting location sends the block through Standby for a fixed settle period, and the block then returns to Run by itself. That period gives a clock source time to settle after it has been reprogrammed.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: In Run, a bus read of address `HALT_ADDR` (default 0x08) with `sleepEn`=1 changes `mode` to 1 (Halt) at the next clock edge.
- R2: A bus read of `HALT_ADDR` or `STBY_ADDR` with `sleepEn`=0 has no effect, and neither has a read or write of any other address apart from `CLKSET_ADDR`. The block stays in Run (`mode`=0).
- R3: The clock enables follow the mode. `mode`=0 gives `cpuClkEn`=1 and `sysClkEn`=1. `mode`=1 gives `cpuClkEn`=0 and `sysClkEn`=1. `mode`=2 gives both at 0.
- R4: In Run, a bus read of `STBY_ADDR` (default 0x0C) with `sleepEn`=1 changes `mode` to 2 (Standby) at the next clock edge.
- R5: A falling edge on `irqN` or on `fiqN` wakes the block from Halt or from Standby. Each line passes through two synchroniser flops, and a fall is the previous sample high with the current sample low. If the line is low before clock edge k, `mode` is 0 after edge k+2 and is still the sleeping mode after edge k+1. A rising edge does not wake the block.
- R6: In Run, a bus write to `CLKSET_ADDR` (default 0x20) makes `mode` 2 at the next edge. The block stays there for exactly `SETTLE_CNT` cycles (default 16) and then returns to 0 without any other input.
- R7: While the block is in Halt or Standby, bus reads and writes have no effect on the mode.
- R8: With `softRstN` low, the block enters Run at the next clock edge from any mode. With `rstN` low, it enters Run at once.
- R9: After reset, `mode`=0, `cpuClkEn`=1 and `sysClkEn`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| softRstN | input | 1 | Synchronous reset, active low |
| busRead | input | 1 | Register bus read strobe, one cycle per access |
| busWrite | input | 1 | Register bus write strobe, one cycle per access |
| busAddr | input | ADDR_W | Register bus address |
| sleepEn | input | 1 | Enables mode entry through halt and standby reads |
| irqN | input | 1 | Normal interrupt line; a falling edge wakes the block |
| fiqN | input | 1 | Fast interrupt line; a falling edge wakes the block |
| cpuClkEn | output | 1 | CPU clock enable |
| sysClkEn | output | 1 | Bus and memory/DMA clock enable |
| mode | output | 2 | Current mode: 0 Run, 1 Halt, 2 Standby |

## Verification
The assertions rely on these assumptions about the inputs:
- `busRead` and `busWrite` are never high in the same cycle.
- Each access lasts a single cycle.
- The interrupt lines change no faster than the synchroniser can follow.

The bench keeps to all three. Every access is one cycle, with the strobes cleared before the next access. An interrupt line is held low for three cycles and then high for three cycles before the next operation starts. The random operations also wait for each mode transition, including the full settle period, to finish before anything else is applied. As a result, no two events overlap in the bench's reference model.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN       = 2'd0,
    PM_HALT      = 2'd1,
    PM_STBY      = 2'd2,
    PM_STBY_AUTO = 2'd3
  } pmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSettle;
    logic runSettle;
  } dpCtrl_t;

  // decoded events from datapath to control
  typedef struct packed {
    logic haltRd;
    logic stbyRd;
    logic clkWr;
    logic wake;
    logic settleDone;
  } dpEvt_t;

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int HALT_ADDR   = 8'h08,
  parameter int STBY_ADDR   = 8'h0C,
  parameter int CLKSET_ADDR = 8'h20,
  parameter int SETTLE_CNT  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              sleepEn,
  input  logic              irqN,
  input  logic              fiqN,
  input  dpCtrl_t           ctrl,
  output dpEvt_t            evt
);

  localparam int NUM_LINES = 2;
  localparam int CNT_W = $clog2(SETTLE_CNT + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CNT - 1);

  logic [NUM_LINES-1:0] lineN;
  logic [NUM_LINES-1:0] lineFall;
  logic [CNT_W-1:0]     settleCnt;

  assign lineN = {fiqN, irqN};

  // two synchroniser flops plus one history flop per line
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    logic [2:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= 3'b111;
      else       pipe <= {pipe[1:0], lineN[g]};
    end
    assign lineFall[g] = pipe[2] & ~pipe[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                settleCnt <= '0;
    else if (ctrl.loadSettle)                 settleCnt <= LOAD_VAL;
    else if (ctrl.runSettle && settleCnt != 0) settleCnt <= settleCnt - 1'b1;
  end

  always_comb begin
    evt.haltRd     = busRead && !busWrite && sleepEn && (busAddr == ADDR_W'(HALT_ADDR));
    evt.stbyRd     = busRead && !busWrite && sleepEn && (busAddr == ADDR_W'(STBY_ADDR));
    evt.clkWr      = busWrite && (busAddr == ADDR_W'(CLKSET_ADDR));
    evt.wake       = |lineFall;
    evt.settleDone = (settleCnt == '0);
  end

  // R6: the settle counter steps down by one each cycle of the automatic standby
  p_settle_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.runSettle && !ctrl.loadSettle && settleCnt != 0) |=> settleCnt == $past(settleCnt) - 1'b1);

  // R5: a wake comes only after the line was seen high and then low
  p_wake_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evt.wake) |-> ($past(irqN) == 1'b0 || $past(fiqN) == 1'b0 || $past(irqN, 2) == 1'b0 || $past(fiqN, 2) == 1'b0));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     softRstN,
  input  dpEvt_t   evt,
  output dpCtrl_t  ctrl,
  output pmState_t state
);

  pmState_t nextState;

  always_comb begin
    nextState       = state;
    ctrl.loadSettle = 1'b0;
    ctrl.runSettle  = (state == PM_STBY_AUTO);
    unique case (state)
      PM_RUN: begin
        if (evt.clkWr) begin
          nextState       = PM_STBY_AUTO;
          ctrl.loadSettle = 1'b1;
        end else if (evt.haltRd) begin
          nextState = PM_HALT;
        end else if (evt.stbyRd) begin
          nextState = PM_STBY;
        end
      end
      PM_HALT, PM_STBY: if (evt.wake) nextState = PM_RUN;
      PM_STBY_AUTO:     if (evt.wake || evt.settleDone) nextState = PM_RUN;
      default:          nextState = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         state <= PM_RUN;
    else if (!softRstN) state <= PM_RUN;
    else               state <= nextState;
  end

  p_wake_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == PM_HALT || state == PM_STBY) && evt.wake) |=> state == PM_RUN);

  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PM_HALT && !evt.wake && softRstN) |=> state == PM_HALT);

  p_stby_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PM_STBY && !evt.wake && softRstN) |=> state == PM_STBY);

  p_soft_rst_r8: assert property (@(posedge clk) disable iff (!rstN)
    !softRstN |=> state == PM_RUN);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int HALT_ADDR   = 8'h08,
  parameter int STBY_ADDR   = 8'h0C,
  parameter int CLKSET_ADDR = 8'h20,
  parameter int SETTLE_CNT  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRstN,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              sleepEn,
  input  logic              irqN,
  input  logic              fiqN,
  output logic              cpuClkEn,
  output logic              sysClkEn,
  output logic [1:0]        mode
);

  dpCtrl_t  ctrl;
  dpEvt_t   evt;
  pmState_t state;

  pwr_mode_dp #(
    .ADDR_W(ADDR_W), .HALT_ADDR(HALT_ADDR), .STBY_ADDR(STBY_ADDR),
    .CLKSET_ADDR(CLKSET_ADDR), .SETTLE_CNT(SETTLE_CNT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .busRead(busRead), .busWrite(busWrite),
    .busAddr(busAddr), .sleepEn(sleepEn), .irqN(irqN), .fiqN(fiqN),
    .ctrl(ctrl), .evt(evt)
  );

  pwr_mode_fsm fsm_i (
    .clk(clk), .rstN(rstN), .softRstN(softRstN),
    .evt(evt), .ctrl(ctrl), .state(state)
  );

  assign cpuClkEn = (state == PM_RUN);
  assign sysClkEn = (state == PM_RUN) || (state == PM_HALT);
  assign mode     = (state == PM_STBY_AUTO) ? 2'd2 : state;

  p_halt_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1) |-> (sysClkEn && !cpuClkEn));

  p_stby_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) |-> (!sysClkEn && !cpuClkEn));

  p_halt_entry_r1: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && busRead && !busWrite && sleepEn && softRstN &&
     busAddr == ADDR_W'(HALT_ADDR)) |=> mode == 2'd1);

  p_no_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && busRead && !busWrite && !sleepEn && softRstN) |=> mode == 2'd0);

  p_stby_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && busRead && !busWrite && sleepEn && softRstN &&
     busAddr == ADDR_W'(STBY_ADDR)) |=> mode == 2'd2);

  p_clkset_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && busWrite && !busRead && softRstN &&
     busAddr == ADDR_W'(CLKSET_ADDR)) |=> mode == 2'd2);

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;

  localparam int SETTLE = 16;
  localparam logic [7:0] A_HALT = 8'h08, A_STBY = 8'h0C, A_CLK = 8'h20;

  logic clk = 1'b0;
  logic rstN = 1'b0, softRstN = 1'b1;
  logic busRead = 1'b0, busWrite = 1'b0, sleepEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic irqN = 1'b1, fiqN = 1'b1;
  logic cpuClkEn, sysClkEn;
  logic [1:0] mode;

  int errors = 0, checks = 0, cycles = 0;
  logic [1:0] expMode;

  always #10 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rstN(rstN), .softRstN(softRstN), .busRead(busRead),
    .busWrite(busWrite), .busAddr(busAddr), .sleepEn(sleepEn),
    .irqN(irqN), .fiqN(fiqN), .cpuClkEn(cpuClkEn), .sysClkEn(sysClkEn), .mode(mode)
  );

  function automatic logic [1:0] expEn(input logic [1:0] m);
    return {m == 2'd0, m != 2'd2};  // {cpu, sys}
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (mode !== exp || {cpuClkEn, sysClkEn} !== expEn(exp)) begin
      errors++;
      $display("FAIL %s: mode=%0d cpu=%0b sys=%0b expected mode=%0d cpu=%0b sys=%0b",
               req, mode, cpuClkEn, sysClkEn, exp, expEn(exp)[1], expEn(exp)[0]);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdAcc(input logic [7:0] a, input logic en);
    busAddr = a; sleepEn = en; busRead = 1'b1;
    step(1);
    busRead = 1'b0; sleepEn = 1'b0;
  endtask

  task automatic wrAcc(input logic [7:0] a);
    busAddr = a; busWrite = 1'b1;
    step(1);
    busWrite = 1'b0;
  endtask

  // drop a line, expect still asleep after 2 edges, awake after 3
  task automatic wakeLine(input bit useFiq, input string req, input logic [1:0] asleep);
    if (useFiq) fiqN = 1'b0; else irqN = 1'b0;
    step(2);
    check(req, asleep);
    step(1);
    check(req, (asleep == 2'd0) ? 2'd0 : 2'd0);
    irqN = 1'b1; fiqN = 1'b1;
    step(3);
  endtask

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    check("R9", 2'd0);

    rdAcc(A_HALT, 1'b0);      check("R2", 2'd0);
    rdAcc(A_STBY, 1'b0);      check("R2", 2'd0);
    rdAcc(8'h10, 1'b1);       check("R2", 2'd0);
    wrAcc(A_HALT);            check("R2", 2'd0);
    rdAcc(A_HALT, 1'b1);      check("R1", 2'd1);
    check("R3", 2'd1);
    rdAcc(A_STBY, 1'b1);      check("R7", 2'd1);
    wrAcc(A_CLK);             check("R7", 2'd1);
    wakeLine(1'b0, "R5", 2'd1);
    check("R5", 2'd0);
    rdAcc(A_STBY, 1'b1);      check("R4", 2'd2);
    check("R3", 2'd2);
    rdAcc(A_HALT, 1'b1);      check("R7", 2'd2);
    wakeLine(1'b1, "R5", 2'd2);

    // rising edge must not wake
    irqN = 1'b0; step(4);
    rdAcc(A_HALT, 1'b1);      check("R5", 2'd1);
    irqN = 1'b1; step(4);     check("R5", 2'd1);
    softRstN = 1'b0; step(1); softRstN = 1'b1;
    check("R8", 2'd0);

    // automatic standby trip
    wrAcc(A_CLK);             check("R6", 2'd2);
    step(SETTLE - 1);         check("R6", 2'd2);
    step(1);                  check("R6", 2'd0);

    // async reset from standby
    rdAcc(A_STBY, 1'b1);
    #3 rstN = 1'b0; #2;       check("R8", 2'd0);
    step(1); rstN = 1'b1; step(1);

    // random mix against model
    expMode = 2'd0;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 5);
      logic en = 1'($urandom_range(0, 1));
      case (op)
        0: begin rdAcc(A_HALT, en); if (expMode == 2'd0 && en) expMode = 2'd1; check("R1", expMode); end
        1: begin rdAcc(A_STBY, en); if (expMode == 2'd0 && en) expMode = 2'd2; check("R4", expMode); end
        2: begin
             if (en) rdAcc(8'h40 + 8'($urandom_range(0, 15)), 1'b1);
             else wrAcc(8'h40 + 8'($urandom_range(0, 15)));
             check("R2", expMode);
           end
        3: begin wakeLine(en, "R5", expMode); expMode = 2'd0; end
        4: begin
             wrAcc(A_CLK);
             check("R6", (expMode == 2'd0) ? 2'd2 : expMode);
             step(SETTLE);
             check("R6", expMode);
           end
        default: begin softRstN = 1'b0; step(1); softRstN = 1'b1; expMode = 2'd0; check("R8", expMode); end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule